// File: doc/BRIEF.md
# Low-Power Entry and Exit Sequencer for DDR2 Memory

This block sits on the controller side of a DDR2 memory interface. It puts the memory into one of two sleep modes and brings it out again. The deep mode keeps the stored data refreshed internally. The light mode only drops the clock enable. The block drives the clock-enable line, the on-die termination enable and a four-bit command bus. It also raises a ready flag that tells the surrounding controller when normal commands may be issued again.

Every wait is a cycle count supplied on an input port. These are: the termination turn-off lead time, the minimum clock-enable-low time, the exit delay before a read, the exit delay before any other command, the light-mode exit latency, and the longest allowed light-mode stay. A leaving deep sleep leaves an outstanding refresh obligation. The controller clears it by pulsing the refresh-issued input.

The states are IDLE, ODT_OFF, SR_HOLD, SR_EXIT, PD_HOLD and PD_EXIT. The transitions are as follows:
- IDLE→ODT_OFF: deep-sleep request accepted.
- ODT_OFF→SR_HOLD: lead time done.
- SR_HOLD→SR_EXIT: request dropped after the minimum time.
- SR_EXIT→IDLE: read exit delay done.
- IDLE→PD_HOLD: light-sleep request accepted.
- PD_HOLD→PD_EXIT: request dropped after the minimum time, or residency limit reached.
- PD_EXIT→IDLE: exit latency done.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset the block is in IDLE with `cke`=1, `odt_en`=1, `ready`=1, `pd_active`=0 and `cmd` = NOP. The command bus is {cs_n, ras_n, cas_n, we_n}, NOP is 4'b0111 and self-refresh entry is 4'b0001. Outside the entry cycle the command bus always carries NOP.
- R2: A deep-sleep request is taken only in IDLE, and only while `banks_idle`=1 and no refresh is owed. Once taken, `ready` and `odt_en` fall on the next cycle. Then `t_odt_off` cycles follow with `cke`=1 and NOP. A request seen while `banks_idle`=0 is ignored.
- R3: Deep sleep starts with exactly one cycle in which `cmd`=4'b0001 and `cke`=0.
- R4: In deep sleep, `cke` stays low for at least `t_cke_min` cycles, counting the entry cycle. After that it stays low for as long as `sr_req` is held.
- R5: On leaving deep sleep, `cke`=1, `odt_en`=0 and `cmd`=NOP for `t_xsrd` cycles. Then the block returns to IDLE.
- R6: During the deep-sleep exit, `ready` rises after `t_xsnr` exit cycles if `next_is_read` was 0 when the exit began. If it was 1, `ready` rises only on the return to IDLE.
- R7: After a deep-sleep exit, deep-sleep requests are ignored until a `ref_issued` pulse has been seen.
- R8: A light-sleep request taken in IDLE gives `cke`=0 with NOP on the next cycle, and `odt_en` is unchanged. `pd_active` is high during the light-sleep stay if `banks_idle` was 0 when the request was taken. When both requests are present and deep sleep is allowed, deep sleep wins.
- R9: In light sleep, `cke` stays low for at least `t_cke_min` cycles, and stays low while `pd_req` is held.
- R10: A light-sleep stay ends after `t_pd_max` low cycles, even if `pd_req` is still high.
- R11: A light-sleep exit holds `cke`=1, NOP and `ready`=0 for `t_xp` cycles before the block returns to IDLE.
- R12: Requests arriving in any state other than IDLE are ignored. A request pulse during an exit leaves the block in IDLE afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Deep-sleep (self-refresh) request, held for the stay |
| pd_req | input | 1 | Light-sleep (power-down) request, held for the stay |
| banks_idle | input | 1 | 1 when every bank is precharged, 0 when a row is open |
| next_is_read | input | 1 | First command after deep-sleep exit is a read |
| ref_issued | input | 1 | Pulse: an auto-refresh was issued |
| t_odt_off | input | CNT_W | Termination-off lead cycles before entry (at least 1) |
| t_cke_min | input | CNT_W | Minimum clock-enable-low cycles (at least 1) |
| t_xsnr | input | CNT_W | Exit cycles before a non-read command |
| t_xsrd | input | CNT_W | Exit cycles before a read (at least t_xsnr, at least 1) |
| t_xp | input | CNT_W | Light-sleep exit latency cycles (at least 1) |
| t_pd_max | input | CNT_W | Light-sleep residency limit (at least t_cke_min) |
| cke | output | 1 | Clock enable to memory |
| odt_en | output | 1 | On-die termination enable |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| ready | output | 1 | Controller may issue commands |
| pd_active | output | 1 | Light-sleep stay with a row open |

## Verification
Deep sleep is exercised three ways:
- with a read exit and with a non-read exit, which separates the two ready delays;
- repeated right after an exit, with no refresh in between, which shows the refresh obligation blocking re-entry;
- with a bank open, which shows the idle-bank condition.

Light sleep is exercised three ways:
- with a short request and a row open, which checks the minimum hold and the active flag;
- with a request held past the limit, which shows the forced wake followed by re-entry;
- with a request pulse during the exit, which shows it being ignored.

Both requests are also raised together to check the priority. The whole sequence is run again with minimal timings, so that counts of one are covered.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ODT_OFF,
        ST_SR_HOLD,
        ST_SR_EXIT,
        ST_PD_HOLD,
        ST_PD_EXIT
    } lpm_state_e;

    typedef logic [3:0] lpm_cmd_t;            // {cs_n, ras_n, cas_n, we_n}
    localparam lpm_cmd_t CMD_NOP = 4'b0111;
    localparam lpm_cmd_t CMD_SRE = 4'b0001;
endpackage

// File: rtl/lpm_phase_timer.sv
module lpm_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (cnt != CNT_TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lpm_refresh_debt.sv
module lpm_refresh_debt (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic owed_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            owed_o <= 1'b0;
        else if (set_i)
            owed_o <= 1'b1;
        else if (clr_i)
            owed_o <= 1'b0;
    end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_req,
    input  logic             pd_req,
    input  logic             banks_idle,
    input  logic             next_is_read,
    input  logic             ref_issued,
    input  logic [CNT_W-1:0] t_odt_off,
    input  logic [CNT_W-1:0] t_cke_min,
    input  logic [CNT_W-1:0] t_xsnr,
    input  logic [CNT_W-1:0] t_xsrd,
    input  logic [CNT_W-1:0] t_xp,
    input  logic [CNT_W-1:0] t_pd_max,
    output logic             cke,
    output logic             odt_en,
    output logic [3:0]       cmd,
    output logic             ready,
    output logic             pd_active
);
    localparam int XW = CNT_W + 1;

    lpm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic [XW-1:0]    elapsed;        // cycles spent in the current state, including this one
    logic             owed_q;
    logic             exit_rd_q;
    logic             row_open_q;
    logic             odt_done, cke_met, xsrd_done, xp_done, pd_limit, xsnr_met;

    assign elapsed   = {1'b0, cnt} + 1'b1;
    assign odt_done  = elapsed >= {1'b0, t_odt_off};
    assign cke_met   = elapsed >= {1'b0, t_cke_min};
    assign xsrd_done = elapsed >= {1'b0, t_xsrd};
    assign xp_done   = elapsed >= {1'b0, t_xp};
    assign pd_limit  = elapsed >= {1'b0, t_pd_max};
    assign xsnr_met  = {1'b0, cnt} >= {1'b0, t_xsnr};

    lpm_phase_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .cnt   (cnt)
    );

    lpm_refresh_debt u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (state_q == ST_SR_HOLD && state_d == ST_SR_EXIT),
        .clr_i  (ref_issued),
        .owed_o (owed_q)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sr_req && banks_idle && !owed_q) state_d = ST_ODT_OFF;
                else if (pd_req)                     state_d = ST_PD_HOLD;
            end
            ST_ODT_OFF: if (odt_done)             state_d = ST_SR_HOLD;
            ST_SR_HOLD: if (cke_met && !sr_req)   state_d = ST_SR_EXIT;
            ST_SR_EXIT: if (xsrd_done)            state_d = ST_IDLE;
            ST_PD_HOLD: if ((cke_met && !pd_req) || pd_limit) state_d = ST_PD_EXIT;
            ST_PD_EXIT: if (xp_done)              state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // State register with the flags captured on transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            exit_rd_q  <= 1'b0;
            row_open_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SR_HOLD && state_d == ST_SR_EXIT)
                exit_rd_q <= next_is_read;
            if (state_q == ST_IDLE && state_d == ST_PD_HOLD)
                row_open_q <= !banks_idle;
        end
    end

    // Outputs
    always_comb begin
        cke       = 1'b1;
        odt_en    = 1'b1;
        cmd       = CMD_NOP;
        ready     = 1'b0;
        pd_active = 1'b0;
        unique case (state_q)
            ST_IDLE:    ready = 1'b1;
            ST_ODT_OFF: odt_en = 1'b0;
            ST_SR_HOLD: begin
                cke    = 1'b0;
                odt_en = 1'b0;
                if (cnt == '0) cmd = CMD_SRE;
            end
            ST_SR_EXIT: begin
                odt_en = 1'b0;
                ready  = !exit_rd_q && xsnr_met;
            end
            ST_PD_HOLD: begin
                cke       = 1'b0;
                pd_active = row_open_q;
            end
            ST_PD_EXIT: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             odt_en,
    input logic [3:0]       cmd,
    input logic             ready,
    input logic             owed,
    input logic [CNT_W-1:0] t_cke_min,
    input logic [CNT_W-1:0] t_pd_max
);
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] SRE = 4'b0001;

    logic [CNT_W:0] low_run;
    logic           in_sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
            in_sr   <= 1'b0;
        end else begin
            if (cke)                low_run <= '0;
            else if (low_run != '1) low_run <= low_run + 1'b1;
            if (cmd == SRE) in_sr <= 1'b1;
            else if (cke)   in_sr <= 1'b0;
        end
    end

    a_r3_entry_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SRE) |-> !cke);

    a_r2_odt_off_before_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SRE) |-> $past(!odt_en));

    a_r7_no_entry_while_owed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SRE) |-> !owed);

    a_r5_nop_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cmd == NOP && !ready));

    a_r4_cke_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (low_run >= {1'b0, t_cke_min}));

    a_r10_pd_residency_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cke) && !in_sr) |-> (low_run <= {1'b0, t_pd_max}));

    a_r6_ready_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cke);
endmodule

bind lpm_sequencer lpm_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .odt_en    (odt_en),
    .cmd       (cmd),
    .ready     (ready),
    .owed      (owed_q),
    .t_cke_min (t_cke_min),
    .t_pd_max  (t_pd_max)
);

// File: tb/lpm_sequencer_test.sv
module lpm_sequencer_test;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_req = 0, pd_req = 0, banks_idle = 1, next_is_read = 0, ref_issued = 0;
    logic [CW-1:0] t_odt_off = 2, t_cke_min = 3, t_xsnr = 4, t_xsrd = 7, t_xp = 3, t_pd_max = 10;
    logic cke, odt_en, ready, pd_active;
    logic [3:0] cmd;

    int checks = 0;
    int errors = 0;

    // behavioural reference: 0 idle, 1 odt lead, 2 deep hold, 3 deep exit, 4 light hold, 5 light exit
    int m_mode = 0;
    int m_n = 0;
    bit m_owed = 0, m_exrd = 0, m_pdact = 0;

    always #5 clk = ~clk;

    lpm_sequencer #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .pd_req(pd_req),
        .banks_idle(banks_idle), .next_is_read(next_is_read), .ref_issued(ref_issued),
        .t_odt_off(t_odt_off), .t_cke_min(t_cke_min), .t_xsnr(t_xsnr), .t_xsrd(t_xsrd),
        .t_xp(t_xp), .t_pd_max(t_pd_max),
        .cke(cke), .odt_en(odt_en), .cmd(cmd), .ready(ready), .pd_active(pd_active)
    );

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit set_owed = 0;
        case (m_mode)
            0: if (sr_req && banks_idle && !m_owed) begin m_mode = 1; m_n = 0; end
               else if (pd_req) begin m_mode = 4; m_n = 0; m_pdact = !banks_idle; end
            1: if (m_n + 1 >= int'(t_odt_off)) begin m_mode = 2; m_n = 0; end else m_n++;
            2: if (m_n + 1 >= int'(t_cke_min) && !sr_req) begin
                   m_mode = 3; m_n = 0; m_exrd = next_is_read; set_owed = 1;
               end else m_n++;
            3: if (m_n + 1 >= int'(t_xsrd)) begin m_mode = 0; m_n = 0; end else m_n++;
            4: if ((m_n + 1 >= int'(t_cke_min) && !pd_req) || m_n + 1 >= int'(t_pd_max)) begin
                   m_mode = 5; m_n = 0;
               end else m_n++;
            5: if (m_n + 1 >= int'(t_xp)) begin m_mode = 0; m_n = 0; end else m_n++;
            default: m_mode = 0;
        endcase
        if (set_owed) m_owed = 1;
        else if (ref_issued) m_owed = 0;
    endtask

    task automatic compare();
        string tg;
        int e_cke, e_odt, e_cmd, e_rdy;
        case (m_mode)
            0: tg = "R1";
            1: tg = "R2";
            2: tg = (m_n == 0) ? "R3" : "R4";
            3: tg = "R5";
            4: tg = "R9";
            default: tg = "R11";
        endcase
        e_cke = (m_mode == 2 || m_mode == 4) ? 0 : 1;
        e_odt = (m_mode >= 1 && m_mode <= 3) ? 0 : 1;
        e_cmd = (m_mode == 2 && m_n == 0) ? 4'b0001 : 4'b0111;
        e_rdy = (m_mode == 0 || (m_mode == 3 && !m_exrd && m_n >= int'(t_xsnr))) ? 1 : 0;
        chk(tg, int'(cke), e_cke, "cke");
        chk(tg, int'(odt_en), e_odt, "odt_en");
        chk(tg, int'(cmd), e_cmd, "cmd");
        chk((m_mode == 3) ? "R6" : tg, int'(ready), e_rdy, "ready");
        chk("R8", int'(pd_active), (m_mode == 4 && m_pdact) ? 1 : 0, "pd_active");
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic scenario(bit full);
        int run;
        // deep sleep, read exit
        banks_idle = 1; next_is_read = 1; sr_req = 1;
        repeat (6) step();
        sr_req = 0;
        repeat (12) step();
        // R7: refresh owed blocks re-entry
        sr_req = 1;
        repeat (4) step();
        chk("R7", int'(odt_en), 1, "odt_en with refresh owed");
        chk("R7", int'(ready), 1, "ready with refresh owed");
        sr_req = 0; ref_issued = 1; step(); ref_issued = 0;
        // deep sleep, non-read exit
        next_is_read = 0; sr_req = 1;
        repeat (2) step();
        sr_req = 0;
        repeat (12) step();
        ref_issued = 1; step(); ref_issued = 0;
        // R2: open bank blocks deep sleep
        banks_idle = 0; sr_req = 1;
        repeat (3) step();
        chk("R2", int'(odt_en), 1, "odt_en with open bank");
        sr_req = 0;
        // light sleep with a row open, short request
        pd_req = 1; step();
        chk("R8", int'(pd_active), 1, "row-open light sleep flag");
        step(); pd_req = 0;
        repeat (8) step();
        // R10: forced wake
        banks_idle = 1; pd_req = 1; step();
        run = 0;
        while (!cke && run < 40) begin run++; step(); end
        chk("R10", run, int'(t_pd_max), "cke-low cycles before forced wake");
        if (full) begin
            // R12: pulse during the exit is ignored
            pd_req = 0; step();
            pd_req = 1; step();
            pd_req = 0;
            repeat (3) step();
            chk("R12", int'(cke), 1, "cke after ignored request pulse");
        end else begin
            pd_req = 0;
            repeat (6) step();
        end
        // R8: both requests, deep sleep wins
        pd_req = 1; sr_req = 1; step();
        chk("R8", int'(cke), 1, "cke when both requested");
        chk("R8", int'(odt_en), 0, "odt_en when both requested");
        pd_req = 0; sr_req = 0;
        repeat (16) step();
        ref_issued = 1; step(); ref_issued = 0;
        repeat (2) step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();
        chk("R1", int'(ready), 1, "ready in reset");
        rst_n = 1;
        step();
        scenario(1'b1);
        t_odt_off = 1; t_cke_min = 1; t_xsnr = 1; t_xsrd = 2; t_xp = 1; t_pd_max = 4;
        step();
        scenario(1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule